// File: doc/BRIEF.md
# Givens-Rotation QR Triangularization Array

This block reduces a small real matrix, up to 3x3 by default, to upper-triangular form with plane rotations. The array is triangular and has one row of cells per output row. Each row has one boundary cell and a number of internal cells. The boundary cell takes the leading element of an arriving vector and combines it with the diagonal value it holds, producing a cosine/sine pair. The internal cells of the same row apply that pair to their held values and to the rest of the vector. The rotated remainder, now one element shorter because its leading entry has been eliminated, moves down to the next row of the array.

Matrix rows enter one per handshake. Each array row runs at its own pace, and valid/ready links between rows absorb the skew. A row of the array can work on matrix row j+1 while the row below it is still working on matrix row j. When the vector flagged as last has passed through the bottom row, the held values form R and can be read in parallel. Matrices smaller than the array are handled by zero padding: unused columns carry zeros, and fewer rows are sent.

The boundary cell uses a multi-cycle digit-serial engine: a square root followed by two divisions. While it runs, the ready signal of that array row is low, so upstream data stalls.

Top module: `qr_givens_array`

## Requirements
- R1: While and directly after reset, `done` is 0, `in_ready` is 1 and every entry of `r_out` is 0.
- R2: Every diagonal entry of R that the array holds is zero or positive, whatever the signs of the input elements.
- R3: Input and output elements are signed 16-bit values with 12 fraction bits. Element j of `in_row` sits at bits [16j+15:16j]. Entry (i,j) of `r_out` sits at bits [16(3i+j)+15:16(3i+j)]. For a full-rank 3x3 matrix whose column norms stay below 8, every upper-triangle entry is within 0.015 of the exact R that has a non-negative diagonal.
- R4: Entries of `r_out` below the diagonal always read 0.
- R5: When a boundary cell receives a zero element and holds a zero value, it applies the identity rotation (cosine 1, sine 0) and does not divide. A matrix with an all-zero leading column therefore gives an all-zero first row of R, and the remaining rows equal the triangular factor of the other columns. An all-zero matrix gives an all-zero R.
- R6: A smaller matrix is accepted by sending zeros in unused columns and asserting `in_last` on its final row. The result equals its triangular factor, with all unused entries 0.
- R7: A row is taken on a rising edge when `in_valid` and `in_ready` are both 1. `in_ready` is then 0 in the next cycle, while the first boundary cell is busy. Data between array rows stays stable while the downstream row is not ready.
- R8: `done` rises once the last row has passed through every array row. It then stays 1, with `r_out` unchanged, until the first row of the next matrix is taken. It is 0 from the following cycle.
- R9: The first row taken after reset or after `done` starts a new matrix. Values held from an earlier matrix have no effect on the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A matrix row is present on `in_row` |
| in_ready | output | 1 | The array can take a row this cycle |
| in_row | input | 48 | One matrix row, three signed Q4.12 elements |
| in_last | input | 1 | Marks the final row of the current matrix |
| done | output | 1 | R is complete and held |
| r_out | output | 144 | R, nine signed Q4.12 entries in row-major order |

## Verification
The bench uses several matrix shapes, and each one isolates a different part of the array:
- A generic full-rank matrix with mixed signs, sent twice, checks the rotation arithmetic. The second run also shows that the array clears its held values between matrices.
- A matrix with negative leading elements shows that the rotation direction always leaves a positive diagonal.
- A zero leading column and an all-zero matrix drive the boundary cells onto the identity path instead of the divider.
- Two-row matrices, both square and rank-limited, show that zero padding and early termination with `in_last` leave the unused entries at zero.

The bench also checks the handshake. It confirms that `in_ready` falls after a row is accepted, that `done` and `r_out` hold while no new matrix arrives, and that `done` clears when the next matrix starts.

// File: rtl/qr_pkg.sv
// Shared state encodings for the Givens QR array.
// Assumes: nothing beyond a synthesizable enum encoding.
package qr_pkg;

    // Flow state of one array row.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROT,
        ST_SEND
    } stage_state_e;

    // Phase of the boundary-cell rotation engine.
    typedef enum logic [1:0] {
        RG_IDLE,
        RG_SQRT,
        RG_DIV,
        RG_FIN
    } rotgen_state_e;

endpackage

// File: rtl/qr_rotgen.sv
// Boundary cell engine. From the held value r (never negative) and an incoming x,
// it forms n = sqrt(r^2 + x^2), c = r/n and s = x/n, all in signed fixed point
// with FRAC fraction bits. The square root is digit-serial, one result bit per
// cycle. The two divisions then run side by side, one quotient bit per cycle.
// A zero pair skips both steps and yields the identity rotation.
// Assumes: r_in >= 0, and start is only raised while the engine is idle.
module qr_rotgen
    import qr_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] r_in,
    input  logic signed [W-1:0] x_in,
    output logic                done,
    output logic signed [W-1:0] c_out,
    output logic signed [W-1:0] s_out,
    output logic signed [W-1:0] n_out
);
    localparam int RW   = W + 1;
    localparam int SQW  = 2 * RW;
    localparam int REMW = RW + 3;
    localparam int DRW  = RW + 2;
    localparam int QW   = FRAC + 2;
    localparam int CNTW = $clog2(RW + 1);
    localparam logic signed [W-1:0] ONE     = W'(2 ** FRAC);
    localparam logic        [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};

    rotgen_state_e      st_q;
    logic [CNTW-1:0]    cnt_q;
    logic [SQW-1:0]     v_q;
    logic [REMW-1:0]    rem_q;
    logic [RW-1:0]      root_q;
    logic [RW-1:0]      ra_q;
    logic [RW-1:0]      xa_q;
    logic               xneg_q;
    logic [DRW-1:0]     dc_q;
    logic [DRW-1:0]     ds_q;
    logic [QW-1:0]      qc_q;
    logic [QW-1:0]      qs_q;

    logic [RW-1:0]        r_mag;
    logic signed [RW-1:0] x_ext;
    logic [RW-1:0]        x_mag;
    logic [SQW-1:0]       sumsq;
    logic [REMW-1:0]      rem_n;
    logic [REMW-1:0]      trial;
    logic                 sq_ge;
    logic                 dc_ge;
    logic                 ds_ge;
    logic [DRW-1:0]       dc_nx;
    logic [DRW-1:0]       ds_nx;
    logic [QW-1:0]        qc_fin;
    logic [QW-1:0]        qs_fin;
    logic signed [W-1:0]  s_mag;

    // Operand magnitudes and the sum of squares.
    always_comb begin
        r_mag = {1'b0, r_in};
        x_ext = RW'(x_in);
        x_mag = x_ext[RW-1] ? RW'(-x_ext) : RW'(x_ext);
        sumsq = SQW'(r_mag) * SQW'(r_mag) + SQW'(x_mag) * SQW'(x_mag);
    end

    // One square-root digit: bring in two radicand bits and try the next root bit.
    always_comb begin
        rem_n = {rem_q[REMW-3:0], v_q[SQW-1 -: 2]};
        trial = {1'b0, root_q, 2'b01};
        sq_ge = (rem_n >= trial);
    end

    // One quotient bit for each of the cosine and sine divisions.
    always_comb begin
        dc_ge  = (dc_q >= DRW'(root_q));
        ds_ge  = (ds_q >= DRW'(root_q));
        dc_nx  = (dc_ge ? dc_q - DRW'(root_q) : dc_q) << 1;
        ds_nx  = (ds_ge ? ds_q - DRW'(root_q) : ds_q) << 1;
        qc_fin = {qc_q[QW-2:0], dc_ge};
        qs_fin = {qs_q[QW-2:0], ds_ge};
        s_mag  = W'(qs_fin);
    end

    // Engine sequencing: capture, root digits, quotient bits, present result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RG_IDLE;
            cnt_q  <= '0;
            v_q    <= '0;
            rem_q  <= '0;
            root_q <= '0;
            ra_q   <= '0;
            xa_q   <= '0;
            xneg_q <= 1'b0;
            dc_q   <= '0;
            ds_q   <= '0;
            qc_q   <= '0;
            qs_q   <= '0;
            c_out  <= ONE;
            s_out  <= '0;
            n_out  <= '0;
        end else begin
            case (st_q)
                RG_IDLE: begin
                    if (start) begin
                        ra_q   <= r_mag;
                        xa_q   <= x_mag;
                        xneg_q <= x_in[W-1];
                        v_q    <= sumsq;
                        rem_q  <= '0;
                        root_q <= '0;
                        cnt_q  <= '0;
                        if (sumsq == '0) begin
                            c_out <= ONE;
                            s_out <= '0;
                            n_out <= '0;
                            st_q  <= RG_FIN;
                        end else begin
                            st_q <= RG_SQRT;
                        end
                    end
                end
                RG_SQRT: begin
                    rem_q  <= sq_ge ? rem_n - trial : rem_n;
                    root_q <= {root_q[RW-2:0], sq_ge};
                    v_q    <= v_q << 2;
                    cnt_q  <= cnt_q + 1'b1;
                    if (cnt_q == CNTW'(RW - 1)) begin
                        cnt_q <= '0;
                        dc_q  <= DRW'(ra_q);
                        ds_q  <= DRW'(xa_q);
                        qc_q  <= '0;
                        qs_q  <= '0;
                        st_q  <= RG_DIV;
                    end
                end
                RG_DIV: begin
                    dc_q  <= dc_nx;
                    ds_q  <= ds_nx;
                    qc_q  <= qc_fin;
                    qs_q  <= qs_fin;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNTW'(FRAC)) begin
                        c_out <= W'(qc_fin);
                        s_out <= xneg_q ? -s_mag : s_mag;
                        n_out <= (root_q > RW'(POS_MAX)) ? POS_MAX : root_q[W-1:0];
                        st_q  <= RG_FIN;
                    end
                end
                default: begin
                    st_q <= RG_IDLE;
                end
            endcase
        end
    end

    assign done = (st_q == RG_FIN);

    // The held diagonal fed back in is never negative.
    assert_diag_in_nonneg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !r_in[W-1]);

    // A zero pair leads directly to the identity rotation.
    assert_zero_pair_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st_q == RG_IDLE && r_in == '0 && x_in == '0)
            |=> (done && c_out == ONE && s_out == '0));

    // The cosine never goes negative and never exceeds one.
    assert_cos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!c_out[W-1] && c_out <= ONE));

endmodule

// File: rtl/qr_cell_int.sv
// Internal cell datapath. It rotates the pair (held q, incoming y) by [c s; -s c]:
// the new held value is c*q + s*y, and the value passed down is c*y - s*q.
// Both results are rescaled by FRAC bits and saturated to W bits.
// Assumes: c and s come from the boundary cell of the same array row.
module qr_cell_int #(
    parameter int W    = 16,
    parameter int FRAC = 12
) (
    input  logic signed [W-1:0] c,
    input  logic signed [W-1:0] s,
    input  logic signed [W-1:0] q,
    input  logic signed [W-1:0] y,
    output logic signed [W-1:0] q_new,
    output logic signed [W-1:0] y_new
);
    localparam int PW = 2 * W + 1;
    localparam logic signed [PW-1:0] HI = PW'((2 ** (W - 1)) - 1);
    localparam logic signed [PW-1:0] LO = -PW'(2 ** (W - 1));

    logic signed [PW-1:0] acc_q;
    logic signed [PW-1:0] acc_y;
    logic signed [PW-1:0] sh_q;
    logic signed [PW-1:0] sh_y;

    // Clamp a rescaled sum into the signed W-bit range.
    function automatic logic signed [W-1:0] clamp(input logic signed [PW-1:0] v);
        if (v > HI)      return W'(HI);
        else if (v < LO) return W'(LO);
        else             return W'(v);
    endfunction

    // Rotate, rescale and saturate both outputs.
    always_comb begin
        acc_q = PW'(c) * PW'(q) + PW'(s) * PW'(y);
        acc_y = PW'(c) * PW'(y) - PW'(s) * PW'(q);
        sh_q  = acc_q >>> FRAC;
        sh_y  = acc_y >>> FRAC;
        q_new = clamp(sh_q);
        y_new = clamp(sh_y);
    end

endmodule

// File: rtl/qr_stage.sv
// One row of the triangular array, which takes vectors of length L. Element 0
// goes to the boundary cell. Elements 1..L-1 go to the internal cells. The
// rotated remainder, L-1 elements long, is offered downstream under valid/ready.
// A vector tagged first clears the held row before it is processed.
// Assumes: the downstream row holds to the same valid/ready rules.
module qr_stage
    import qr_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 12,
    parameter int L    = 3,
    localparam int LO  = (L > 1) ? L - 1 : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    output logic            in_rdy,
    input  logic [L*W-1:0]  in_vec,
    input  logic            in_first,
    input  logic            in_last,
    output logic            out_vld,
    input  logic            out_rdy,
    output logic [LO*W-1:0] out_vec,
    output logic            out_first,
    output logic            out_last,
    output logic [L*W-1:0]  r_row,
    output logic            fin_last
);
    stage_state_e        st_q;
    logic [L*W-1:0]      x_q;
    logic                first_q;
    logic                last_q;
    logic signed [W-1:0] diag_q;

    logic                start;
    logic signed [W-1:0] rg_r;
    logic                rot_done;
    logic signed [W-1:0] rot_c;
    logic signed [W-1:0] rot_s;
    logic signed [W-1:0] rot_n;
    logic                accept;

    assign accept = (st_q == ST_IDLE) && in_vld;
    assign start  = accept;
    assign rg_r   = in_first ? '0 : diag_q;

    qr_rotgen #(.W(W), .FRAC(FRAC)) u_boundary (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .r_in  (rg_r),
        .x_in  (in_vec[W-1:0]),
        .done  (rot_done),
        .c_out (rot_c),
        .s_out (rot_s),
        .n_out (rot_n)
    );

    // Row sequencing: accept a vector, wait for the rotation, hand off the remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            x_q      <= '0;
            first_q  <= 1'b0;
            last_q   <= 1'b0;
            diag_q   <= '0;
            fin_last <= 1'b0;
        end else begin
            fin_last <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (in_vld) begin
                        x_q     <= in_vec;
                        first_q <= in_first;
                        last_q  <= in_last;
                        if (in_first) diag_q <= '0;
                        st_q    <= ST_ROT;
                    end
                end
                ST_ROT: begin
                    if (rot_done) begin
                        diag_q   <= rot_n;
                        fin_last <= last_q;
                        st_q     <= (L > 1) ? ST_SEND : ST_IDLE;
                    end
                end
                default: begin
                    if (out_rdy) st_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign in_rdy    = (st_q == ST_IDLE);
    assign out_vld   = (L > 1) && (st_q == ST_SEND);
    assign out_first = first_q;
    assign out_last  = last_q;
    assign r_row[W-1:0] = diag_q;

    if (L > 1) begin : g_int
        for (genvar j = 1; j < L; j++) begin : g_cell
            logic signed [W-1:0] q_r;
            logic signed [W-1:0] y_r;
            logic signed [W-1:0] q_nx;
            logic signed [W-1:0] y_nx;

            qr_cell_int #(.W(W), .FRAC(FRAC)) u_cell (
                .c     (rot_c),
                .s     (rot_s),
                .q     (q_r),
                .y     ($signed(x_q[j*W +: W])),
                .q_new (q_nx),
                .y_new (y_nx)
            );

            // Held value and forwarded remainder of internal cell j.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_r <= '0;
                    y_r <= '0;
                end else if (accept && in_first) begin
                    q_r <= '0;
                end else if (st_q == ST_ROT && rot_done) begin
                    q_r <= q_nx;
                    y_r <= y_nx;
                end
            end

            assign r_row[j*W +: W]       = q_r;
            assign out_vec[(j-1)*W +: W] = y_r;
        end
    end else begin : g_no_int
        assign out_vec = '0;
    end

    // The remainder stays put while the row below is not ready.
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy) |=> (out_vld && $stable(out_vec)));

    // The held diagonal of this row is never negative.
    assert_diag_nonneg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_q[W-1]);

endmodule

// File: rtl/qr_givens_array.sv
// Top of the triangular Givens QR array, with N rows of cells. Matrix rows enter
// one per handshake. Array row k works on vectors of length N-k, and the rows are
// chained by valid/ready links. After the last row has cleared the bottom of the
// array, done is raised and R is read in parallel, row-major.
// Assumes: column norms stay below the Q format range; a smaller matrix is zero padded.
module qr_givens_array
    import qr_pkg::*;
#(
    parameter int N    = 3,
    parameter int W    = 16,
    parameter int FRAC = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [N*W-1:0]   in_row,
    input  logic             in_last,
    output logic             done,
    output logic [N*N*W-1:0] r_out
);
    logic [N*W-1:0] bus_vec   [N+1];
    logic           bus_vld   [N+1];
    logic           bus_rdy   [N+1];
    logic           bus_first [N+1];
    logic           bus_last  [N+1];
    logic [N*W-1:0] row_bus   [N];
    logic           fin       [N];

    logic done_q;
    logic await_q;
    logic accept;

    assign accept       = in_valid && in_ready;
    assign bus_vec[0]   = in_row;
    assign bus_vld[0]   = in_valid;
    assign in_ready     = bus_rdy[0];
    assign bus_first[0] = await_q;
    assign bus_last[0]  = in_last;
    assign bus_rdy[N]   = 1'b1;

    for (genvar k = 0; k < N; k++) begin : g_row
        localparam int L  = N - k;
        localparam int LO = (L > 1) ? L - 1 : 1;
        logic [LO*W-1:0] o_vec;
        logic [L*W-1:0]  r_row;

        qr_stage #(.W(W), .FRAC(FRAC), .L(L)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_vld    (bus_vld[k]),
            .in_rdy    (bus_rdy[k]),
            .in_vec    (bus_vec[k][L*W-1:0]),
            .in_first  (bus_first[k]),
            .in_last   (bus_last[k]),
            .out_vld   (bus_vld[k+1]),
            .out_rdy   (bus_rdy[k+1]),
            .out_vec   (o_vec),
            .out_first (bus_first[k+1]),
            .out_last  (bus_last[k+1]),
            .r_row     (r_row),
            .fin_last  (fin[k])
        );

        assign bus_vec[k+1] = (N*W)'(o_vec);
        assign row_bus[k]   = (N*W)'(r_row);
    end

    for (genvar i = 0; i < N; i++) begin : g_out_r
        for (genvar j = 0; j < N; j++) begin : g_out_c
            if (j >= i) begin : g_upper
                assign r_out[(i*N+j)*W +: W] = row_bus[i][(j-i)*W +: W];
            end else begin : g_lower
                assign r_out[(i*N+j)*W +: W] = '0;
            end
        end
    end

    // Completion flag, and marking of the next row as the start of a new matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            await_q <= 1'b1;
        end else if (fin[N-1]) begin
            done_q  <= 1'b1;
            await_q <= 1'b1;
        end else if (accept && await_q) begin
            done_q  <= 1'b0;
            await_q <= 1'b0;
        end
    end

    assign done = done_q;

    // Once raised, done holds until a new matrix begins.
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accept) |=> done);

    // Taking the first row of a new matrix clears done.
    assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bus_first[0]) |=> !done);

    // The input side is busy in the cycle after a row is taken.
    assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

endmodule

// File: tb/qr_givens_array_tb.sv
// Scoreboard bench: the driver pushes the expected R entries into a queue, and a
// monitor pops and compares them when done rises.
module qr_givens_array_tb;
    localparam int  N     = 3;
    localparam int  W     = 16;
    localparam real SCALE = 4096.0;
    localparam real TOL   = 0.015;

    logic             clk;
    logic             rst_n;
    logic             in_valid;
    logic             in_ready;
    logic [N*W-1:0]   in_row;
    logic             in_last;
    logic             done;
    logic [N*N*W-1:0] r_out;

    int    n_cmp;
    int    n_bad;
    bit    finished;
    real   mat   [3][3];
    real   exp_r [3][3];
    real   exp_q [$];
    string tag_q [$];

    qr_givens_array u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_row   (in_row),
        .in_last  (in_last),
        .done     (done),
        .r_out    (r_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input real got, input real expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %f expected %f", req, what, got, expv);
        end
    endtask

    task automatic set_mat(input real a0, input real a1, input real a2,
                           input real b0, input real b1, input real b2,
                           input real c0, input real c1, input real c2);
        mat[0][0] = a0; mat[0][1] = a1; mat[0][2] = a2;
        mat[1][0] = b0; mat[1][1] = b1; mat[1][2] = b2;
        mat[2][0] = c0; mat[2][1] = c1; mat[2][2] = c2;
    endtask

    // Reference R from modified Gram-Schmidt with a non-negative diagonal.
    task automatic push_expected(input int rows, input string tag);
        real qv [3][3];
        real v [3];
        for (int j = 0; j < 3; j++) begin
            real nrm;
            for (int r = 0; r < 3; r++) v[r] = (r < rows) ? mat[r][j] : 0.0;
            for (int i = 0; i < 3; i++) begin
                if (i < j) begin
                    real d;
                    d = 0.0;
                    for (int r = 0; r < 3; r++) d += qv[i][r] * v[r];
                    exp_r[i][j] = d;
                    for (int r = 0; r < 3; r++) v[r] -= d * qv[i][r];
                end else if (i > j) begin
                    exp_r[i][j] = 0.0;
                end
            end
            nrm = 0.0;
            for (int r = 0; r < 3; r++) nrm += v[r] * v[r];
            nrm = $sqrt(nrm);
            if (nrm < 1.0e-9) begin
                exp_r[j][j] = 0.0;
                for (int r = 0; r < 3; r++) qv[j][r] = 0.0;
            end else begin
                exp_r[j][j] = nrm;
                for (int r = 0; r < 3; r++) qv[j][r] = v[r] / nrm;
            end
        end
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++) begin
                exp_q.push_back(exp_r[i][j]);
                tag_q.push_back((i > j) ? "R4" : tag);
            end
    endtask

    // Present one matrix row and hold it until it is taken.
    task automatic send_row(input int r, input bit last);
        in_valid = 1'b1;
        in_last  = last;
        for (int j = 0; j < 3; j++) in_row[j*W +: W] = W'($rtoi(mat[r][j] * SCALE));
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (!done) check(1'b0, "R8", "done never rose", 0.0, 1.0);
    endtask

    task automatic run_matrix(input int rows, input string tag);
        push_expected(rows, tag);
        for (int r = 0; r < rows; r++) send_row(r, r == rows - 1);
        wait_done();
    endtask

    // Monitor: compares all nine entries when done rises.
    initial begin
        bit seen;
        seen = 1'b0;
        forever begin
            @(negedge clk);
            if (done && !seen) begin
                seen = 1'b1;
                for (int idx = 0; idx < 9; idx++) begin
                    real got;
                    real e;
                    string tg;
                    got = $itor($signed(r_out[idx*W +: W])) / SCALE;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected result", got, 0.0);
                    end else begin
                        e  = exp_q.pop_front();
                        tg = tag_q.pop_front();
                        if (idx % 3 < idx / 3)
                            check(got == 0.0, tg, $sformatf("entry %0d", idx), got, e);
                        else
                            check((got - e <= TOL) && (e - got <= TOL), tg,
                                  $sformatf("entry %0d", idx), got, e);
                        if (idx % 4 == 0)
                            check(got >= 0.0, "R2", $sformatf("diag %0d sign", idx), got, e);
                    end
                end
            end else if (!done) begin
                seen = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N*N*W-1:0] saved;
        n_cmp    = 0;
        n_bad    = 0;
        finished = 1'b0;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_row   = '0;
        repeat (3) @(negedge clk);
        // R1: state while in reset.
        check(done == 1'b0, "R1", "done in reset", $itor(done), 0.0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", $itor(in_ready), 1.0);
        check(r_out == '0, "R1", "r_out in reset", (r_out == '0) ? 0.0 : 1.0, 0.0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: generic full-rank matrix; R7: ready drops after a take.
        set_mat(1.5, 0.5, -0.25,  0.75, 1.0, 0.5,  -0.5, 0.25, 1.25);
        push_expected(3, "R3");
        send_row(0, 1'b0);
        check(in_ready == 1'b0, "R7", "in_ready after take", $itor(in_ready), 0.0);
        send_row(1, 1'b0);
        send_row(2, 1'b1);
        wait_done();

        // R8: result held while idle.
        saved = r_out;
        repeat (12) @(negedge clk);
        check(done == 1'b1, "R8", "done held", $itor(done), 1.0);
        check(r_out == saved, "R8", "r_out held", (r_out == saved) ? 1.0 : 0.0, 1.0);

        // R3/R2: negative leading elements; R8: done clears on new matrix.
        set_mat(-1.0, 2.0, 0.5,  -0.5, -1.0, 1.0,  0.25, 0.5, -1.5);
        push_expected(3, "R3");
        send_row(0, 1'b0);
        check(done == 1'b0, "R8", "done after new first row", $itor(done), 0.0);
        send_row(1, 1'b0);
        send_row(2, 1'b1);
        wait_done();

        // R5: zero leading column, then an all-zero matrix.
        set_mat(0.0, 1.0, 0.5,  0.0, 0.5, -1.0,  0.0, -0.75, 0.25);
        run_matrix(3, "R5");
        set_mat(0.0, 0.0, 0.0,  0.0, 0.0, 0.0,  0.0, 0.0, 0.0);
        run_matrix(3, "R5");

        // R6: 2x2 padded, then 2x3 with two rows.
        set_mat(1.25, -0.5, 0.0,  0.5, 1.0, 0.0,  0.0, 0.0, 0.0);
        run_matrix(2, "R6");
        set_mat(0.5, 1.0, 1.5,  1.0, -0.5, 0.75,  0.0, 0.0, 0.0);
        run_matrix(2, "R6");

        // R9: first matrix again after others; held state must not leak.
        set_mat(1.5, 0.5, -0.25,  0.75, 1.0, 0.5,  -0.5, 0.25, 1.25);
        run_matrix(3, "R9");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8", "results pending", $itor(exp_q.size()), 0.0);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule